// File: doc/BRIEF.md
# Hypercube All-to-All Exchange Step Sequencer

This block schedules a complete exchange among `2^DIM` nodes of a hypercube. After a start pulse it walks through a series of steps. Each step is an XOR permutation: node `i` talks to node `i ^ mask`. In every valid cycle the block presents the active mask and a packed vector that gives each node its partner index. When the schedule is finished it raises a one-clock done pulse and returns to idle. The block does not move any message data.

Two modes are available, and the mode is captured when the run starts. In single mode one permutation is issued per step, with the mask counting down from all-ones to zero. The final, zero-mask step is the node's local copy. In paired mode the block also issues the bitwise complement of each mask in the same step. A mask and its complement never load the same link, so nodes that can drive two links finish in half the steps. The first paired step combines the all-ones exchange with the local copy.

The step outputs form a stream with `stall_i` acting as back-pressure. While `stall_i` is high, the step on the outputs is held unchanged. The step counts as consumed only on a cycle in which `step_vld_o` is high and `stall_i` is low.

Top module: `xchg_sched`

## Requirements
- R1: During and directly after reset the block is idle: `step_vld_o`, `done_o` and `pair_vld_o` are 0 and both masks are 0.
- R2: A `start_i` pulse sampled while idle makes `step_vld_o` high on the next cycle, showing step 0. A `start_i` pulse sampled while a run is in progress has no effect on the sequence.
- R3: In single mode (`pair_i`=0 at start) there are `2^DIM` steps. Step s shows `mask_a_o` = `2^DIM-1-s`, `pair_vld_o`=0 and `mask_b_o`=0.
- R4: In paired mode (`pair_i`=1 at start) there are `2^(DIM-1)` steps. Step s shows `mask_a_o` = `2^DIM-1-s`, `mask_b_o` = s and `pair_vld_o`=1, so the two masks XOR to all ones.
- R5: Field i of `dest_a_o` (bits `i*DIM +: DIM`) equals `i ^ mask_a_o`. Field i of `dest_b_o` equals `i ^ mask_b_o`, which is i itself outside paired steps.
- R6: While `step_vld_o` and `stall_i` are both high, the next cycle shows the same step with the same masks.
- R7: `done_o` is high for exactly one cycle: the cycle after the last step is consumed. `step_vld_o` is 0 in that cycle, and the block is idle afterwards.
- R8: `pair_i` is sampled only when a run starts. Changing it during a run does not alter that run's masks or its step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a schedule when idle |
| pair_i | input | 1 | Mode select captured at start: 1 = paired masks |
| stall_i | input | 1 | Holds the current step |
| step_vld_o | output | 1 | A step is presented |
| mask_a_o | output | DIM | Primary XOR mask |
| mask_b_o | output | DIM | Complementary mask (paired mode) |
| pair_vld_o | output | 1 | `mask_b_o` is a live second permutation |
| dest_a_o | output | 2^DIM*DIM | Per-node partner under `mask_a_o` |
| dest_b_o | output | 2^DIM*DIM | Per-node partner under `mask_b_o` |
| done_o | output | 1 | One-cycle pulse after the final step |

## Verification
The bench builds two copies of the block, one with `DIM`=3 and one with `DIM`=1, and drives both from the same inputs. With eight nodes it can check every mask in both modes, the full partner vector, a stall in the middle of a run, and start and mode changes during a run. The one-bit copy reaches the edge case of the shortest possible schedule. There, paired mode has a single step that is also the last, so done must follow directly after it.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_RUN  = 2'd1,
    XS_FIN  = 2'd2
  } xs_state_e;
endpackage

// File: rtl/xs_step_ctr.sv
module xs_step_ctr #(
  parameter int DIM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stall,
  input  logic           pair_req,
  output logic           running,
  output logic           paired,
  output logic [DIM-1:0] step,
  output logic           done
);
  import xs_pkg::*;

  localparam int NODES     = 1 << DIM;
  localparam int LAST_ONE  = NODES - 1;
  localparam int LAST_PAIR = NODES / 2 - 1;

  xs_state_e     state_q;
  logic [DIM-1:0] step_q;
  logic           paired_q;
  logic [DIM-1:0] last_idx;
  logic           consume;

  assign last_idx = paired_q ? DIM'(LAST_PAIR) : DIM'(LAST_ONE);
  assign consume  = (state_q == XS_RUN) && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= XS_IDLE;
      step_q   <= '0;
      paired_q <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: if (start) begin
          state_q  <= XS_RUN;
          step_q   <= '0;
          paired_q <= pair_req;
        end
        XS_RUN: if (consume) begin
          if (step_q == last_idx) begin
            state_q <= XS_FIN;
            step_q  <= '0;
          end else begin
            step_q <= step_q + DIM'(1);
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign running = (state_q == XS_RUN);
  assign paired  = paired_q;
  assign step    = step_q;
  assign done    = (state_q == XS_FIN);

  // R3/R4: an accepted non-final step advances the index by one
  p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !stall && step_q != last_idx) |=> (running && step_q == $past(step_q) + DIM'(1)));

  // R6: a stalled step keeps its index
  p_stall_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && stall) |=> (running && $stable(step_q)));

  // R8: mode stays fixed while running
  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(paired_q));
endmodule

// File: rtl/xs_mask_gen.sv
module xs_mask_gen #(
  parameter int DIM = 3
) (
  input  logic           running,
  input  logic           paired,
  input  logic [DIM-1:0] step,
  output logic [DIM-1:0] mask_a,
  output logic [DIM-1:0] mask_b,
  output logic           pair_vld
);
  // all-ones minus step equals the bitwise complement of step
  always_comb begin
    mask_a   = running ? ~step : '0;
    mask_b   = (running && paired) ? step : '0;
    pair_vld = running && paired;
  end
endmodule

// File: rtl/xs_dest_map.sv
module xs_dest_map #(
  parameter int DIM = 3
) (
  input  logic [DIM-1:0]            mask,
  output logic [(1<<DIM)*DIM-1:0]   dest
);
  localparam int NODES = 1 << DIM;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    assign dest[n*DIM +: DIM] = DIM'(n) ^ mask;
  end
endmodule

// File: rtl/xchg_sched.sv
module xchg_sched #(
  parameter int DIM = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       pair_i,
  input  logic                       stall_i,
  output logic                       step_vld_o,
  output logic [DIM-1:0]             mask_a_o,
  output logic [DIM-1:0]             mask_b_o,
  output logic                       pair_vld_o,
  output logic [(1<<DIM)*DIM-1:0]    dest_a_o,
  output logic [(1<<DIM)*DIM-1:0]    dest_b_o,
  output logic                       done_o
);
  logic           running;
  logic           paired;
  logic [DIM-1:0] step;

  xs_step_ctr #(.DIM(DIM)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .stall    (stall_i),
    .pair_req (pair_i),
    .running  (running),
    .paired   (paired),
    .step     (step),
    .done     (done_o)
  );

  xs_mask_gen #(.DIM(DIM)) u_mask (
    .running  (running),
    .paired   (paired),
    .step     (step),
    .mask_a   (mask_a_o),
    .mask_b   (mask_b_o),
    .pair_vld (pair_vld_o)
  );

  xs_dest_map #(.DIM(DIM)) u_dst_a (.mask(mask_a_o), .dest(dest_a_o));
  xs_dest_map #(.DIM(DIM)) u_dst_b (.mask(mask_b_o), .dest(dest_b_o));

  assign step_vld_o = running;

  // R4: paired masks never share a link
  p_pair_complement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_o |-> ((mask_a_o ^ mask_b_o) == '1));

  // R5: node 0 partner equals the mask itself
  p_node0_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld_o |-> (dest_a_o[DIM-1:0] == mask_a_o));

  // R6: held step shows identical masks
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_vld_o && stall_i) |=> (step_vld_o && $stable(mask_a_o) && $stable(mask_b_o)));

  // R7: done lasts one cycle and never overlaps a step
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!step_vld_o ##1 !done_o));

  // R1: idle outputs carry no masks
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !step_vld_o |-> (mask_a_o == '0 && !pair_vld_o));
endmodule

// File: tb/test_xchg_sched.sv
module test_xchg_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, pair_i = 1'b0, stall_i = 1'b0;

  logic        vld3, pv3, done3;
  logic [2:0]  ma3, mb3;
  logic [23:0] da3, db3;
  logic        vld1, pv1, done1;
  logic [0:0]  ma1, mb1;
  logic [1:0]  da1, db1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  xchg_sched #(.DIM(3)) i_xchg_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pair_i(pair_i), .stall_i(stall_i),
    .step_vld_o(vld3), .mask_a_o(ma3), .mask_b_o(mb3), .pair_vld_o(pv3),
    .dest_a_o(da3), .dest_b_o(db3), .done_o(done3));

  xchg_sched #(.DIM(1)) i_xchg_sched_d1 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pair_i(pair_i), .stall_i(stall_i),
    .step_vld_o(vld1), .mask_a_o(ma1), .mask_b_o(mb1), .pair_vld_o(pv1),
    .dest_a_o(da1), .dest_b_o(db1), .done_o(done1));

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_step3(input int s, input bit paired);
    chk(vld3, 1, "R2 valid");
    chk(ma3, 7 - s, paired ? "R4 mask_a" : "R3 mask_a");
    chk(pv3, paired, paired ? "R4 pair_vld" : "R3 pair_vld");
    chk(mb3, paired ? s : 0, paired ? "R4 mask_b" : "R3 mask_b");
    for (int i = 0; i < 8; i++) begin
      chk(da3[i*3 +: 3], i ^ (7 - s), "R5 dest_a");
      chk(db3[i*3 +: 3], paired ? (i ^ s) : i, "R5 dest_b");
    end
  endtask

  task automatic pulse_start(input bit paired);
    @(negedge clk);
    pair_i = paired;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_d3(input bit paired, input int stall_at, input bit disturb);
    int steps;
    steps = paired ? 4 : 8;
    pulse_start(paired);
    for (int s = 0; s < steps; s++) begin
      chk_step3(s, paired);
      if (disturb && s == 1) begin
        start_i = 1'b1;      // R2: ignored while running
        pair_i = ~paired;    // R8: ignored while running
      end
      if (s == stall_at) begin
        stall_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stall_i = 1'b0;
        chk_step3(s, paired);  // R6 held step
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(done3, 1, "R7 done high");
    chk(vld3, 0, "R7 valid low at done");
    @(negedge clk);
    chk(done3, 0, "R7 done one cycle");
    chk(vld3, 0, "R7 idle after done");
    pair_i = 1'b0;
  endtask

  task automatic wait_idle3;
    while (vld3 || done3) @(negedge clk);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk(vld3, 0, "R1 valid");
    chk(done3, 0, "R1 done");
    chk(pv3, 0, "R1 pair_vld");
    chk(ma3, 0, "R1 mask_a");
    chk(mb3, 0, "R1 mask_b");
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld3, 0, "R1 valid after release");
  endtask

  task automatic test_d1;
    pulse_start(1'b0);
    chk(vld1, 1, "R3 d1 valid");
    chk(ma1, 1, "R3 d1 first mask");
    chk(da1, 2'b01, "R5 d1 dest");
    @(negedge clk);
    chk(ma1, 0, "R3 d1 local mask");
    @(negedge clk);
    chk(done1, 1, "R7 d1 done");
    wait_idle3();
    pulse_start(1'b1);
    chk(ma1, 1, "R4 d1 mask_a");
    chk(mb1, 0, "R4 d1 mask_b");
    chk(pv1, 1, "R4 d1 pair_vld");
    @(negedge clk);
    chk(done1, 1, "R7 d1 done after single paired step");
    chk(vld1, 0, "R7 d1 valid low");
    wait_idle3();
  endtask

  initial begin
    test_reset();
    run_d3(1'b0, -1, 1'b0);
    run_d3(1'b1, -1, 1'b0);
    run_d3(1'b0, 3, 1'b1);
    run_d3(1'b1, 2, 1'b1);
    run_d3(1'b1, 3, 1'b0);
    test_d1();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule